// File: doc/BRIEF.md
# Push-button stopwatch with seven-segment digits

This block keeps elapsed time as six decimal digits (minutes, seconds and hundredths of a second) and shows each digit as a seven-segment pattern. A divider counts system clock cycles and produces a one-cycle step strobe every 10 ms. On each strobe, while the stopwatch is running, the lowest digit advances. The higher digits follow through a carry chain of mixed radix.

Three active-low momentary buttons control it: one starts or resumes, one pauses, and one clears. A stored run flag keeps the chosen mode after the button is let go. The buttons are sampled on the clock edge and are assumed to be already debounced. The divider only counts while the stopwatch is running, so a pause keeps the partial interval toward the next step.

Top module: `stopwatch_core`

## Requirements
- R1: While `rst_n` is low, and after it rises, all six digits read 0 and the stopwatch is paused.
- R2: A low `btn_start_n` at a clock edge, with the other two buttons high, puts the stopwatch into the running state. It stays running after the button returns high.
- R3: A low `btn_pause_n` at a clock edge, with `btn_clear_n` high, puts the stopwatch into the paused state. It stays paused after release.
- R4: A low `btn_clear_n` at a clock edge sets every digit to 0, enters the paused state and restarts the step divider. This applies whatever the other two buttons are doing.
- R5: When start and pause are both low at the same edge, the result is paused.
- R6: With DIV = CLK_HZ/STEP_HZ, the lowest digit advances once every DIV clock edges spent in the running state. The first advance comes DIV edges after the edge that starts the run. Partial progress toward the next step is kept across a pause.
- R7: Digits 0, 1, 2 and 4 count 0 to 9, and digits 3 and 5 count 0 to 5. A digit wraps to 0 after its maximum. A digit advances only on a step in which every lower digit is at its maximum.
- R8: `seg0`/`seg1` show hundredths units/tens, `seg2`/`seg3` show seconds units/tens, and `seg4`/`seg5` show minutes units/tens.
- R9: Segments are active low, with bit 0 = segment a through bit 6 = segment g. The codes for 0..9 are 40, 79, 24, 30, 19, 12, 02, 78, 00, 10 (hex).
- R10: While paused, no digit changes, however many clock cycles pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| btn_start_n | input | 1 | Start/resume button, low while pressed |
| btn_pause_n | input | 1 | Pause button, low while pressed |
| btn_clear_n | input | 1 | Clear button, low while pressed |
| seg0 | output | 7 | Hundredths units pattern |
| seg1 | output | 7 | Hundredths tens pattern |
| seg2 | output | 7 | Seconds units pattern |
| seg3 | output | 7 | Seconds tens pattern |
| seg4 | output | 7 | Minutes units pattern |
| seg5 | output | 7 | Minutes tens pattern |

## Verification
A wrong run flag shows up at `seg0` within DIV cycles as a count that moves while it should be frozen, or that stays frozen while it should move. A wrong divider phase shifts the first advance by a cycle. A missing or premature carry shows as a wrong higher digit at the first wrap of the digit below it: 1 s, 10 s, 1 min or 10 min of stepping. To reach these points, the bench runs a reference count of running edges and compares all six patterns at every checkpoint.

// File: rtl/stopwatch_core.sv
module stopwatch_core #(
  parameter int CLK_HZ  = 50_000_000,
  parameter int STEP_HZ = 100
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       btn_start_n,
  input  logic       btn_pause_n,
  input  logic       btn_clear_n,
  output logic [6:0] seg0,
  output logic [6:0] seg1,
  output logic [6:0] seg2,
  output logic [6:0] seg3,
  output logic [6:0] seg4,
  output logic [6:0] seg5
);
  localparam int NDIG = 6;
  localparam int DIV = CLK_HZ / STEP_HZ;
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] RELOAD = DW'(DIV - 1);

  function automatic logic [6:0] seg_of(input logic [3:0] v);
    case (v)
      4'd0: seg_of = 7'h40;
      4'd1: seg_of = 7'h79;
      4'd2: seg_of = 7'h24;
      4'd3: seg_of = 7'h30;
      4'd4: seg_of = 7'h19;
      4'd5: seg_of = 7'h12;
      4'd6: seg_of = 7'h02;
      4'd7: seg_of = 7'h78;
      4'd8: seg_of = 7'h00;
      4'd9: seg_of = 7'h10;
      default: seg_of = 7'h7F;
    endcase
  endfunction

  wire clr = ~btn_clear_n;
  wire pse = ~btn_pause_n;
  wire sta = ~btn_start_n;

  logic          run_q;
  logic [DW-1:0] div_q;
  logic          tick;
  logic [NDIG-1:0]   adv;
  logic [4*NDIG-1:0] dig_flat;
  logic [6:0]        seg [NDIG];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)          run_q <= 1'b0;
    else if (clr || pse) run_q <= 1'b0;
    else if (sta)        run_q <= 1'b1;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)     div_q <= RELOAD;
    else if (clr)   div_q <= RELOAD;
    else if (run_q) div_q <= (div_q == '0) ? RELOAD : div_q - 1'b1;

  assign tick   = run_q && (div_q == '0);
  assign adv[0] = tick;

  for (genvar g = 0; g < NDIG; g++) begin : dg
    localparam logic [3:0] TOP = (g == 3 || g == 5) ? 4'd5 : 4'd9;
    logic [3:0] d;

    always_ff @(posedge clk or negedge rst_n)
      if (!rst_n)      d <= 4'd0;
      else if (clr)    d <= 4'd0;
      else if (adv[g]) d <= (d == TOP) ? 4'd0 : d + 4'd1;

    if (g < NDIG - 1) begin : cy
      assign adv[g+1] = adv[g] && (d == TOP);
    end

    assign dig_flat[4*g +: 4] = d;
    assign seg[g] = seg_of(d);
  end

  assign seg0 = seg[0];
  assign seg1 = seg[1];
  assign seg2 = seg[2];
  assign seg3 = seg[3];
  assign seg4 = seg[4];
  assign seg5 = seg[5];
endmodule

// File: rtl/stopwatch_core_chk.sv
module stopwatch_core_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start_n,
  input logic        pause_n,
  input logic        clear_n,
  input logic        run,
  input logic        tick,
  input logic [23:0] digs
);
  AST_CLEAR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clear_n |=> (digs == 24'd0) && !run); // R4
  AST_PAUSE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && !pause_n |=> !run); // R5
  AST_START_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && pause_n && !start_n |=> run); // R2
  AST_MODE_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && pause_n && start_n |=> run == $past(run)); // R3
  AST_NO_STEP_PAUSED: assert property (@(posedge clk) disable iff (!rst_n)
    !run |-> !tick); // R10
  AST_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && !tick |=> $stable(digs)); // R10
  AST_LOW_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    clear_n && tick && digs[3:0] != 4'd9 |=> digs[3:0] == $past(digs[3:0]) + 4'd1); // R6
  AST_DIGIT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    digs[3:0] <= 4'd9 && digs[7:4] <= 4'd9 && digs[11:8] <= 4'd9 &&
    digs[15:12] <= 4'd5 && digs[19:16] <= 4'd9 && digs[23:20] <= 4'd5); // R7
endmodule

bind stopwatch_core stopwatch_core_chk chk_i (
  .clk(clk), .rst_n(rst_n), .start_n(btn_start_n), .pause_n(btn_pause_n),
  .clear_n(btn_clear_n), .run(run_q), .tick(tick), .digs(dig_flat));

// File: tb/stopwatch_core_tb_top.sv
module stopwatch_core_tb_top;
  localparam int TB_DIV = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start_n = 1'b1, pause_n = 1'b1, clear_n = 1'b1;
  logic [6:0] s0, s1, s2, s3, s4, s5;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  stopwatch_core #(.CLK_HZ(200), .STEP_HZ(100)) dut_i (
    .clk(clk), .rst_n(rst_n), .btn_start_n(start_n), .btn_pause_n(pause_n),
    .btn_clear_n(clear_n), .seg0(s0), .seg1(s1), .seg2(s2), .seg3(s3),
    .seg4(s4), .seg5(s5));

  // reference: count of clock edges spent running
  logic m_run;
  int   m_edges;
  always @(posedge clk or negedge rst_n)
    if (!rst_n) begin m_run <= 1'b0; m_edges <= 0; end
    else if (!clear_n) begin m_run <= 1'b0; m_edges <= 0; end
    else begin
      if (m_run) m_edges <= m_edges + 1;
      if (!pause_n) m_run <= 1'b0;
      else if (!start_n) m_run <= 1'b1;
    end

  function automatic logic [6:0] code(input int v);
    logic [6:0] t [10] = '{7'h40, 7'h79, 7'h24, 7'h30, 7'h19,
                           7'h12, 7'h02, 7'h78, 7'h00, 7'h10};
    return t[v];
  endfunction

  task automatic chk(input string tag, input logic [6:0] act, input logic [6:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag);
    int t = m_edges / TB_DIV;
    int cs = t % 100, sec = (t / 100) % 60, mn = (t / 6000) % 60;
    chk({tag, " R8 seg0"}, s0, code(cs % 10));
    chk({tag, " R8 seg1"}, s1, code(cs / 10));
    chk({tag, " R8 seg2"}, s2, code(sec % 10));
    chk({tag, " R8 seg3"}, s3, code(sec / 10));
    chk({tag, " R8 seg4"}, s4, code(mn % 10));
    chk({tag, " R8 seg5"}, s5, code(mn / 10));
  endtask

  task automatic press(input bit st, input bit pa, input bit cl);
    @(negedge clk);
    start_n = !st; pause_n = !pa; clear_n = !cl;
    @(negedge clk);
    start_n = 1'b1; pause_n = 1'b1; clear_n = 1'b1;
  endtask

  task automatic t_reset;
    @(negedge clk);
    chk("R1 seg0 in reset", s0, 7'h40);
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    chk("R1 seg5 after reset", s5, 7'h40);
    chk("R9 zero code", s3, 7'h40);
    chk_all("R1 paused after reset");
  endtask

  task automatic t_first_step;
    press(1, 0, 0);
    chk("R6 no step at run start", s0, 7'h40);
    @(negedge clk);
    chk("R6 no step after 1 edge", s0, 7'h40);
    @(negedge clk);
    chk("R6 step after DIV edges", s0, 7'h79);
    repeat (2) @(negedge clk);
    chk("R9 two code", s0, 7'h24);
    repeat (40) @(negedge clk);
    chk_all("R2 still running after release");
  endtask

  task automatic t_pause;
    logic [6:0] h;
    @(negedge clk);
    press(0, 1, 0);
    h = s0;
    repeat (30) @(negedge clk);
    chk("R10 frozen while paused", s0, h);
    chk_all("R3 paused held");
    press(1, 0, 0);
    repeat (7) @(negedge clk);
    chk_all("R6 resume keeps phase");
    press(0, 1, 0);
  endtask

  task automatic t_both;
    logic [6:0] h;
    press(1, 1, 0);
    h = s0;
    repeat (10) @(negedge clk);
    chk("R5 pause beats start", s0, h);
    press(1, 0, 0);
    repeat (9) @(negedge clk);
    chk_all("R2 runs again");
  endtask

  task automatic t_clear;
    press(1, 1, 1);
    chk_all("R4 clear with all buttons");
    chk("R4 zero seg0", s0, 7'h40);
    repeat (10) @(negedge clk);
    chk("R4 stays paused", s0, 7'h40);
  endtask

  task automatic t_carry;
    press(1, 0, 0);
    repeat (250) @(negedge clk);
    chk_all("R7 hundredths wrap");
    repeat (2000 - 250) @(negedge clk);
    chk_all("R7 ten seconds");
    press(0, 1, 0);
    chk_all("R7 after carry pause");
  endtask

  task automatic t_minutes;
    press(0, 0, 1);
    press(1, 0, 0);
    repeat (12000) @(negedge clk);
    chk("R7 one minute seg4", s4, 7'h79);
    chk("R7 one minute seg3", s3, 7'h40);
    repeat (120000 - 12000) @(negedge clk);
    chk("R7 ten minutes seg5", s5, 7'h79);
    chk_all("R7 ten minutes all");
  endtask

  initial begin
    t_reset();
    t_first_step();
    t_pause();
    t_both();
    t_clear();
    t_carry();
    t_minutes();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule